// File: doc/BRIEF.md
# Serial DAC Write Controller

This block is the host side of a three-wire link to a 16-bit serial digital-to-analog converter. A code offered on a valid/ready handshake is framed by an active-low chip select and shifted out most significant bit first on a data line, one bit per serial clock pulse. After the frame, the converter's output latch is updated in one of two ways. In the first, the block drives a separate active-low load strobe. In the second, the load strobe is held low so that the converter updates on the closing edge of chip select.

Every timing minimum of the converter is a parameter counted in system-clock cycles. These are the serial clock high and low halves, the lead from chip select to the first clock, the lag after the last clock, the chip-select-high gap between frames, the delay and width of the load strobe, and the width of a reset pulse. After reset the block waits a power-up interval before it offers its first ready. A reset-pulse command drives the converter's active-low reset line. A code presented together with that command is kept and is sent once the pulse ends.

Top module: `dac_wr_ctrl`

## Requirements
- R1: While reset is applied and during the PWRUP_CYC cycles that follow, dac_cs_n=1, dac_sclk=0, dac_ldac_n=1, dac_rst_n=1 and in_ready=0, and in_valid is ignored. in_ready rises after exactly PWRUP_CYC rising clock edges following reset release.
- R2: On the edge that accepts a code (in_valid and in_ready both high), dac_cs_n goes low with dac_sdi equal to bit 15 of the code. dac_sclk stays low for LEAD_CYC cycles before its first rise.
- R3: A frame holds exactly 16 dac_sclk pulses. Each pulse is high for HALF_CYC cycles, with HALF_CYC low cycles between pulses. Pulse k (k=0..15) carries bit 15-k of the code, so the most significant bit goes first. dac_sdi changes only on the edge where dac_sclk falls, and never while dac_sclk is high.
- R4: dac_cs_n stays low for LAG_CYC cycles after the 16th pulse falls, then rises.
- R5: With pulse_mode=1 sampled at acceptance, dac_ldac_n stays high while dac_cs_n is low. It falls LDAC_DLY_CYC cycles after dac_cs_n rises and stays low for LDAC_W_CYC cycles.
- R6: With pulse_mode=0 sampled at acceptance, dac_ldac_n is low from the accepting edge onward and no strobe phase is inserted. Changes on pulse_mode and in_data after acceptance do not affect the running frame.
- R7: in_ready is low from acceptance until GAP_CYC cycles after the last frame event: the rise of dac_cs_n in held mode, or the return of dac_ldac_n in pulse mode. It then returns high.
- R8: rst_req=1 while in_ready=1 drives dac_rst_n low for RST_W_CYC cycles, with dac_cs_n high and in_ready low. The block is then idle and ready again.
- R9: A code presented with rst_req in the same cycle is accepted. Its frame starts (dac_cs_n falls) on the same edge at which dac_rst_n returns high, and it carries that code with the timing of R2 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A code is offered |
| in_ready | output | 1 | Block is idle and will take a code |
| in_data | input | 16 | Code to send, bit 15 first |
| pulse_mode | input | 1 | 1: strobe the load line after the frame; 0: hold it low |
| rst_req | input | 1 | Request a reset pulse on the converter |
| dac_cs_n | output | 1 | Chip select to converter, active low |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdi | output | 1 | Serial data to converter |
| dac_ldac_n | output | 1 | Load strobe, active low |
| dac_rst_n | output | 1 | Converter reset, active low |

## Verification
Every converter-side output is a register loaded from the next state. Each one therefore moves on the very edge that accepts a code, and the bench counts that cycle as zero. From there each phase boundary falls at a fixed sum of the timing parameters: lead, then 31 half periods, then lag, then strobe delay and width, then gap. The bench samples all five outputs and in_ready on every falling clock edge of a transaction and compares them with a schedule it computes from those sums. A reset pulse shifts the whole schedule by the reset width. Power-up readiness is checked one cycle before and exactly at the parameterised count.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

   typedef enum logic [3:0] {
      ST_PWRUP,
      ST_IDLE,
      ST_RSTP,
      ST_LEAD,
      ST_SCKH,
      ST_SCKL,
      ST_LAG,
      ST_LDDLY,
      ST_LDW,
      ST_GAP
   } dacw_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dacw_timer.sv
// Down-counting phase timer: loaded with (length - 1) on phase entry,
// done reads high in the last cycle of the phase.
module dacw_timer #(
   parameter int CNT_W    = 8,
   parameter int INIT_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= CNT_W'(INIT_VAL);
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/dacw_shreg.sv
// Serial word register: MSB presented on msb, shifted toward the MSB on
// each falling serial clock, with a count of bits already sent.
module dacw_shreg #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              shift,
   output logic              msb,
   output logic              last
);

   localparam int CW = $clog2(DATA_W);

   logic [DATA_W-1:0] sr_q;
   logic [CW-1:0]     sent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         sent_q <= '0;
      end else if (load) begin
         sr_q   <= load_data;
         sent_q <= '0;
      end else if (shift) begin
         sr_q   <= {sr_q[DATA_W-2:0], 1'b0};
         sent_q <= sent_q + 1'b1;
      end
   end

   assign msb  = sr_q[DATA_W-1];
   assign last = (sent_q == CW'(DATA_W-1));

   // R3: the controller never asks for a shift beyond the final bit
   p_no_overshift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      shift |-> !last);

   // R3: a word is never reloaded in the middle of a frame
   p_no_midload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !shift);

endmodule

// File: rtl/dac_wr_ctrl.sv
module dac_wr_ctrl
   import dacw_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int HALF_CYC     = 1,
   parameter int LEAD_CYC     = 1,
   parameter int LAG_CYC      = 1,
   parameter int GAP_CYC      = 2,
   parameter int LDAC_DLY_CYC = 2,
   parameter int LDAC_W_CYC   = 2,
   parameter int RST_W_CYC    = 1,
   parameter int PWRUP_CYC    = 500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              pulse_mode,
   input  logic              rst_req,
   output logic              dac_cs_n,
   output logic              dac_sclk,
   output logic              dac_sdi,
   output logic              dac_ldac_n,
   output logic              dac_rst_n
);

   localparam int N_TIM = 8;
   localparam int TIMING [N_TIM] = '{HALF_CYC, LEAD_CYC, LAG_CYC, GAP_CYC,
                                     LDAC_DLY_CYC, LDAC_W_CYC, RST_W_CYC, PWRUP_CYC};
   localparam int MAX_CYC = imax(imax(imax(HALF_CYC, LEAD_CYC), imax(LAG_CYC, GAP_CYC)),
                                 imax(imax(LDAC_DLY_CYC, LDAC_W_CYC), imax(RST_W_CYC, PWRUP_CYC)));
   localparam int CNT_W = $clog2(MAX_CYC + 1);

   localparam logic [CNT_W-1:0] TV_HALF = CNT_W'(HALF_CYC - 1);
   localparam logic [CNT_W-1:0] TV_LEAD = CNT_W'(LEAD_CYC - 1);
   localparam logic [CNT_W-1:0] TV_LAG  = CNT_W'(LAG_CYC - 1);
   localparam logic [CNT_W-1:0] TV_GAP  = CNT_W'(GAP_CYC - 1);
   localparam logic [CNT_W-1:0] TV_LDD  = CNT_W'(LDAC_DLY_CYC - 1);
   localparam logic [CNT_W-1:0] TV_LDW  = CNT_W'(LDAC_W_CYC - 1);
   localparam logic [CNT_W-1:0] TV_RSTW = CNT_W'(RST_W_CYC - 1);
   localparam logic [CNT_W-1:0] TV_PWUP = CNT_W'(PWRUP_CYC);

   // Elaboration-time parameter checks
   for (genvar gi = 0; gi < N_TIM; gi++) begin : g_tim_chk
      if (TIMING[gi] < 1) begin : g_bad
         $error("dac_wr_ctrl: timing parameter %0d must be at least one cycle", gi);
      end
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("dac_wr_ctrl: DATA_W must be at least 2");
   end

   dacw_state_e      state_q, nstate;
   logic             t_load, t_done;
   logic [CNT_W-1:0] t_val;
   logic             sh_shift, sh_last, sh_msb;
   logic             accept;
   logic             pend_q;
   logic             mode_q, nmode;
   logic             cs_n_q, sclk_q, ldac_n_q, rstn_q;
   logic [CNT_W-1:0] up_cnt_q;

   assign in_ready = (state_q == ST_IDLE);
   assign accept   = in_valid && in_ready;
   assign nmode    = accept ? pulse_mode : mode_q;

   dacw_timer #(
      .CNT_W    (CNT_W),
      .INIT_VAL (PWRUP_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .done     (t_done)
   );

   dacw_shreg #(
      .DATA_W (DATA_W)
   ) u_shreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_data (in_data),
      .shift     (sh_shift),
      .msb       (sh_msb),
      .last      (sh_last)
   );

   // Phase sequencer
   always_comb begin
      nstate   = state_q;
      t_load   = 1'b0;
      t_val    = '0;
      sh_shift = 1'b0;
      unique case (state_q)
         ST_PWRUP: begin
            if (t_done) nstate = ST_IDLE;
         end
         ST_IDLE: begin
            if (rst_req) begin
               nstate = ST_RSTP;  t_load = 1'b1;  t_val = TV_RSTW;
            end else if (in_valid) begin
               nstate = ST_LEAD;  t_load = 1'b1;  t_val = TV_LEAD;
            end
         end
         ST_RSTP: begin
            if (t_done) begin
               if (pend_q) begin
                  nstate = ST_LEAD;  t_load = 1'b1;  t_val = TV_LEAD;
               end else begin
                  nstate = ST_IDLE;
               end
            end
         end
         ST_LEAD: begin
            if (t_done) begin
               nstate = ST_SCKH;  t_load = 1'b1;  t_val = TV_HALF;
            end
         end
         ST_SCKH: begin
            if (t_done) begin
               t_load = 1'b1;
               if (sh_last) begin
                  nstate = ST_LAG;   t_val = TV_LAG;
               end else begin
                  nstate = ST_SCKL;  t_val = TV_HALF;  sh_shift = 1'b1;
               end
            end
         end
         ST_SCKL: begin
            if (t_done) begin
               nstate = ST_SCKH;  t_load = 1'b1;  t_val = TV_HALF;
            end
         end
         ST_LAG: begin
            if (t_done) begin
               t_load = 1'b1;
               if (mode_q) begin
                  nstate = ST_LDDLY;  t_val = TV_LDD;
               end else begin
                  nstate = ST_GAP;    t_val = TV_GAP;
               end
            end
         end
         ST_LDDLY: begin
            if (t_done) begin
               nstate = ST_LDW;  t_load = 1'b1;  t_val = TV_LDW;
            end
         end
         ST_LDW: begin
            if (t_done) begin
               nstate = ST_GAP;  t_load = 1'b1;  t_val = TV_GAP;
            end
         end
         ST_GAP: begin
            if (t_done) nstate = ST_IDLE;
         end
         default: nstate = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_PWRUP;
         pend_q  <= 1'b0;
         mode_q  <= 1'b1;
      end else begin
         state_q <= nstate;
         mode_q  <= nmode;
         if (accept && rst_req)              pend_q <= 1'b1;
         else if (state_q == ST_RSTP && t_done) pend_q <= 1'b0;
      end
   end

   // Registered pin drivers, decoded from the next phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n_q   <= 1'b1;
         sclk_q   <= 1'b0;
         ldac_n_q <= 1'b1;
         rstn_q   <= 1'b1;
      end else begin
         cs_n_q   <= !(nstate inside {ST_LEAD, ST_SCKH, ST_SCKL, ST_LAG});
         sclk_q   <= (nstate == ST_SCKH);
         ldac_n_q <= nmode ? (nstate != ST_LDW) : 1'b0;
         rstn_q   <= (nstate != ST_RSTP);
      end
   end

   assign dac_cs_n   = cs_n_q;
   assign dac_sclk   = sclk_q;
   assign dac_sdi    = sh_msb;
   assign dac_ldac_n = ldac_n_q;
   assign dac_rst_n  = rstn_q;

   // Cycles since reset, saturating at the power-up interval (checks only)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 up_cnt_q <= '0;
      else if (up_cnt_q != TV_PWUP) up_cnt_q <= up_cnt_q + 1'b1;
   end

   // R1: readiness never precedes the full power-up interval
   p_pwrup_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (up_cnt_q == TV_PWUP));

   // R3: serial clock pulses only inside a frame
   p_sclk_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dac_sclk |-> !dac_cs_n);

   // R3: data is steady on and across the high half of every pulse
   p_sdi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dac_sclk |-> $stable(dac_sdi));

   // R2: chip select opens with the clock low
   p_cs_open_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_cs_n) |-> !dac_sclk);

   // R5: in strobe mode the load line is never low with chip select low
   p_ldac_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && !dac_ldac_n) |-> dac_cs_n);

   // R6: a held-mode frame opens with the load line already low
   p_held_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dac_cs_n) && !mode_q) |-> !dac_ldac_n);

   // R7: ready only with the link quiet
   p_ready_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (dac_cs_n && dac_rst_n && !dac_sclk));

   // R8: no frame overlaps a reset pulse
   p_rst_no_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_rst_n |-> dac_cs_n);

endmodule

// File: tb/tb_dac_wr_ctrl.sv
`timescale 1ns/1ps
module tb_dac_wr_ctrl;

   localparam int H  = 2;
   localparam int LD = 3;
   localparam int LG = 2;
   localparam int GP = 3;
   localparam int DD = 2;
   localparam int DW = 4;
   localparam int RW = 3;
   localparam int PU = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_data = '0;
   logic        pulse_mode = 1'b1;
   logic        rst_req = 1'b0;
   logic        dac_cs_n, dac_sclk, dac_sdi, dac_ldac_n, dac_rst_n;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   dac_wr_ctrl #(
      .DATA_W (16), .HALF_CYC (H), .LEAD_CYC (LD), .LAG_CYC (LG), .GAP_CYC (GP),
      .LDAC_DLY_CYC (DD), .LDAC_W_CYC (DW), .RST_W_CYC (RW), .PWRUP_CYC (PU)
   ) dut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
      .in_data (in_data), .pulse_mode (pulse_mode), .rst_req (rst_req),
      .dac_cs_n (dac_cs_n), .dac_sclk (dac_sclk), .dac_sdi (dac_sdi),
      .dac_ldac_n (dac_ldac_n), .dac_rst_n (dac_rst_n)
   );

   // {pulse_mode, code}
   localparam logic [16:0] VEC [8] = '{
      {1'b1, 16'hA5C3}, {1'b1, 16'h0000}, {1'b0, 16'hFFFF}, {1'b0, 16'h8001},
      {1'b1, 16'h1234}, {1'b0, 16'h7FFE}, {1'b1, 16'hFFFF}, {1'b0, 16'h0001}
   };

   typedef struct packed {
      logic cs;
      logic sclk;
      logic ldac;
      logic rdy;
      logic rst;
      int   bit_idx;
      int   req;
   } exp_t;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Expected pin levels t cycles after the accepting edge
   function automatic exp_t expect_at(input int t, input bit pm, input int off);
      exp_t e;
      int   s;
      e.cs = 1'b1; e.sclk = 1'b0; e.ldac = pm; e.rdy = 1'b0; e.rst = 1'b1;
      e.bit_idx = -1; e.req = 7;
      s = t - off;
      if (s < 0) begin e.rst = 1'b0; e.req = 8; return e; end
      if (s < LD) begin e.cs = 1'b0; e.bit_idx = 0; e.req = 2; return e; end
      s -= LD;
      if (s < 31*H) begin
         e.cs = 1'b0; e.sclk = ((s / H) % 2 == 0);
         e.bit_idx = ((s / H) + 1) / 2; e.req = 3; return e;
      end
      s -= 31*H;
      if (s < LG) begin e.cs = 1'b0; e.bit_idx = 15; e.req = 4; return e; end
      s -= LG;
      if (pm) begin
         if (s < DD) begin e.req = 5; return e; end
         s -= DD;
         if (s < DW) begin e.ldac = 1'b0; e.req = 5; return e; end
         s -= DW;
      end
      if (s < GP) begin e.req = 7; return e; end
      e.rdy = 1'b1;
      return e;
   endfunction

   task automatic wait_ready();
      while (!in_ready) @(negedge clk);
   endtask

   task automatic run_frame(input logic [15:0] code, input bit pm, input bit with_rst);
      int          err [9];
      logic [15:0] got;
      int          off, total;
      exp_t        e;
      off   = with_rst ? RW : 0;
      total = off + LD + 31*H + LG + (pm ? DD + DW : 0) + GP;
      foreach (err[i]) err[i] = 0;
      got = '0;
      wait_ready();
      in_data = code; pulse_mode = pm; in_valid = 1'b1; rst_req = with_rst;
      @(negedge clk);
      // R6: inputs changed after acceptance must not reach the frame
      in_valid = 1'b0; rst_req = 1'b0; pulse_mode = ~pm; in_data = ~code;
      for (int t = 0; t <= total; t++) begin
         e = expect_at(t, pm, off);
         if (dac_cs_n   !== e.cs)   err[e.req]++;
         if (dac_sclk   !== e.sclk) err[e.req]++;
         if (dac_ldac_n !== e.ldac) err[pm ? e.req : 6]++;
         if (in_ready   !== e.rdy)  err[7]++;
         if (dac_rst_n  !== e.rst)  err[8]++;
         if (e.bit_idx >= 0) begin
            if (dac_sdi !== code[15 - e.bit_idx]) err[(e.req == 2) ? 2 : 3]++;
            if (e.sclk) got[15 - e.bit_idx] = dac_sdi;
         end
         if (t < total) @(negedge clk);
      end
      check(err[2] == 0, "R2", "lead phase mismatches", err[2], 0);
      check(err[3] == 0, "R3", "shift phase mismatches", err[3], 0);
      check(got == code, "R3", "word sampled on clock rises", got, code);
      check(err[4] == 0, "R4", "lag phase mismatches", err[4], 0);
      if (pm) check(err[5] == 0, "R5", "load strobe mismatches", err[5], 0);
      else    check(err[6] == 0, "R6", "held load line mismatches", err[6], 0);
      check(err[7] == 0, "R7", "ready/gap mismatches", err[7], 0);
      check(err[8] == 0, "R8", "reset line mismatches", err[8], 0);
      if (with_rst)
         check(err[2] + err[3] + err[4] == 0 && got == code, "R9",
               "held code frame after reset pulse", got, code);
   endtask

   task automatic reset_only();
      int bad;
      bad = 0;
      wait_ready();
      rst_req = 1'b1;
      @(negedge clk);
      rst_req = 1'b0;
      for (int t = 0; t <= RW; t++) begin
         if (dac_rst_n !== (t >= RW)) bad++;
         if (in_ready  !== (t >= RW)) bad++;
         if (dac_cs_n  !== 1'b1)      bad++;
         if (t < RW) @(negedge clk);
      end
      check(bad == 0, "R8", "standalone reset pulse mismatches", bad, 0);
   endtask

   initial begin : main
      int bad;
      repeat (3) @(negedge clk);
      // R1: idle levels under reset
      check(dac_cs_n   === 1'b1, "R1", "cs_n in reset",   dac_cs_n,   1);
      check(dac_sclk   === 1'b0, "R1", "sclk in reset",   dac_sclk,   0);
      check(dac_ldac_n === 1'b1, "R1", "ldac_n in reset", dac_ldac_n, 1);
      check(dac_rst_n  === 1'b1, "R1", "rst_n in reset",  dac_rst_n,  1);
      check(in_ready   === 1'b0, "R1", "ready in reset",  in_ready,   0);
      rst_n = 1'b1;
      in_valid = 1'b1; in_data = 16'hDEAD;
      bad = 0;
      for (int k = 0; k < PU - 1; k++) begin
         @(negedge clk);
         if (dac_cs_n !== 1'b1 || in_ready !== 1'b0) bad++;
      end
      in_valid = 1'b0;
      check(bad == 0, "R1", "activity during power-up wait", bad, 0);
      check(in_ready === 1'b0, "R1", "ready one cycle early", in_ready, 0);
      @(negedge clk);
      check(in_ready === 1'b1, "R1", "ready at power-up count", in_ready, 1);

      foreach (VEC[i]) run_frame(VEC[i][15:0], VEC[i][16], 1'b0);

      reset_only();
      run_frame(16'hC35A, 1'b1, 1'b1);
      run_frame(16'h5A3C, 1'b0, 1'b1);
      run_frame(16'h8000, 1'b1, 1'b0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", 20000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule